// File: doc/BRIEF.md
# Power Monitor Serial Command and Readback Slave

This block is the two-wire serial slave of a supply power monitor. It watches a raw clock and data pair, sampled with a much faster system clock, and answers its own 7-bit address. The upper five bits of that address are fixed and the lower two come from a board strap. The data line is driven only low, open-drain style, through an output-enable signal.

A write transfer carries one of two things in its first data byte. A byte with a clear top bit is a command: it starts or stops conversions of the voltage and current channels, either continuously or as a one-shot request, picks the voltage range, and can switch readback to a status byte. A byte with a set top bit names an extended register, and the next byte is handed to that register through a one-cycle write strobe.

Read transfers return the latest 12-bit voltage and current results, packed into two or three bytes, or the status byte alone. The conversion requests go out as levels to an external sequencer. The sequencer reports each finished conversion with a done pulse and its result. While a one-shot request is still open, a read is refused at the address. The bytes of a read are frozen into a shadow copy at the moment the address is accepted.

Top module: `pmon_i2c_slave`

## Requirements
- R1: The slave acknowledges only the address formed by the fixed upper bits 10110 followed by `strap_i[1:0]`, sent MSB first with the R/W bit last (0 write, 1 read). With strap 00 the write byte is 0xB0, and with strap 10 it is 0xB4. Any other address is not acknowledged, and SDA stays released for the rest of that transfer.
- R2: A write transfer that carries only the address and then ends with STOP is acknowledged and changes no output.
- R3: A first written byte with bit 7 = 0 is a command. Its bits set the outputs as follows: bit 0 drives `volt_cont_o`, bit 2 drives `curr_cont_o`, bit 4 drives `vrange_o`, bit 1 raises `volt_once_o` and bit 3 raises `curr_once_o`. Bit 6 selects status readback and bit 5 is ignored. After reset all of these outputs are 0.
- R4: A first written byte with bit 7 = 1 stores its bits 1:0 as a register selector. The next written byte then appears on `ext_data_o`, with that selector on `ext_sel_o` and a one-cycle `ext_wr_o` pulse. A selector of 0 produces no pulse.
- R5: A one-shot request clears itself: `volt_once_o` (or `curr_once_o`) stays high until the matching done pulse arrives, and falls on the cycle after it.
- R6: While either one-shot request is open, a read address is not acknowledged. A write address is still acknowledged.
- R7: Every command write clears both stored results. A read in continuous mode before the first done pulse is therefore acknowledged and returns zero bytes.
- R8: With both channels enabled (bit 0 or 1, and bit 2 or 3), a read returns three bytes: voltage bits 11:4, then current bits 11:4, then voltage bits 3:0 in the upper nibble with current bits 3:0 in the lower nibble.
- R9: With one channel enabled, a read returns two bytes: that channel's bits 11:4, then its bits 3:0 in the upper nibble with a zero lower nibble.
- R10: With command bit 6 set, a read returns one byte, the value of `status_i` at the address phase. This takes precedence over the channel enables.
- R11: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more before the next START.
- R12: A START at any point restarts address reception, and a STOP at any point returns the slave to idle with SDA released. A byte cut off by a STOP has no effect.
- R13: The bytes of a read are captured when the read address is acknowledged. Done pulses that arrive later in that read do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 2 | Board strap giving the two low address bits |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| volt_res_i | input | 12 | Voltage result from the sequencer |
| volt_done_i | input | 1 | One-cycle pulse: voltage result valid |
| curr_res_i | input | 12 | Current result from the sequencer |
| curr_done_i | input | 1 | One-cycle pulse: current result valid |
| status_i | input | 8 | Status byte returned in status readback |
| volt_cont_o | output | 1 | Continuous voltage conversion request |
| volt_once_o | output | 1 | Open one-shot voltage request |
| curr_cont_o | output | 1 | Continuous current conversion request |
| curr_once_o | output | 1 | Open one-shot current request |
| vrange_o | output | 1 | Voltage range select |
| ext_wr_o | output | 1 | One-cycle extended register write strobe |
| ext_sel_o | output | 2 | Extended register selector |
| ext_data_o | output | 8 | Extended register write data |

## Verification
The readback path is driven by a table of command bytes paired with distinct result patterns: both channels, voltage only, current only, one-shot on both, and status. Each result uses different nibbles in every position, so a swapped byte, a swapped nibble or a dropped padding nibble shows up as a wrong value, not a lucky match. Directed sequences cover address matching under two strap values, the refused read while a one-shot is open and its recovery after the done pulse, zeros before the first continuous result, extended writes with a valid and a zero selector, and a byte cut short by STOP. A final case changes the results in the middle of a read, which tells a frozen shadow apart from a live mux.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int RES_W = 12;
  localparam int LO_W  = RES_W - 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK
  } bus_st_e;

  // Bytes of a read, first byte in the top octet.
  function automatic logic [23:0] pack_read(
    input logic             sel_st,
    input logic             en_v,
    input logic             en_i,
    input logic [RES_W-1:0] v,
    input logic [RES_W-1:0] i,
    input logic [7:0]       st
  );
    if (sel_st)            return {st, 16'h0000};
    if (en_v && en_i)      return {v[RES_W-1:LO_W], i[RES_W-1:LO_W], v[LO_W-1:0], i[LO_W-1:0]};
    if (en_v)              return {v[RES_W-1:LO_W], v[LO_W-1:0], {(8-LO_W){1'b0}}, 8'h00};
    if (en_i)              return {i[RES_W-1:LO_W], i[LO_W-1:0], {(8-LO_W){1'b0}}, 8'h00};
    return 24'h000000;
  endfunction
endpackage

// File: rtl/pmon_bus_sampler.sv
module pmon_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/pmon_bus_fsm.sv
module pmon_bus_fsm
  import pmon_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b10110
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  strap_i,
  input  logic        sda_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        busy_i,
  input  logic [23:0] shadow_i,
  output logic        sda_oe_o,
  output logic        cmd_wr_o,
  output logic        ext_req_o,
  output logic [1:0]  ext_sel_o,
  output logic        shadow_ld_o,
  output logic [7:0]  wdata_o
);
  bus_st_e    state_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q, tx_q, rd_byte;
  logic       rw_q, ptr_v_q, mack_q;
  logic [1:0] widx_q, ridx_q, ptr_q;

  always_comb begin
    case (ridx_q)
      2'd0:    rd_byte = shadow_i[23:16];
      2'd1:    rd_byte = shadow_i[15:8];
      2'd2:    rd_byte = shadow_i[7:0];
      default: rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      rw_q <= 1'b0; ptr_v_q <= 1'b0; mack_q <= 1'b0;
      widx_q <= '0; ridx_q <= '0; ptr_q <= '0;
      sda_oe_o <= 1'b0; cmd_wr_o <= 1'b0; ext_req_o <= 1'b0; shadow_ld_o <= 1'b0;
    end else begin
      cmd_wr_o    <= 1'b0;
      ext_req_o   <= 1'b0;
      shadow_ld_o <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR; cnt_q <= '0; sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE; sda_oe_o <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_WBYTE: begin
            if (rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (fall_i && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[7:1] == {ADDR_HI, strap_i} && (!sh_q[0] || !busy_i)) begin
                  state_q <= ST_AACK; sda_oe_o <= 1'b1; rw_q <= sh_q[0];
                  widx_q <= '0; ridx_q <= '0; ptr_v_q <= 1'b0;
                  shadow_ld_o <= sh_q[0];
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                state_q <= ST_WACK; sda_oe_o <= 1'b1;
                if (widx_q == 2'd0) begin
                  if (!sh_q[7]) cmd_wr_o <= 1'b1;
                  else begin ptr_q <= sh_q[1:0]; ptr_v_q <= 1'b1; end
                end else if (widx_q == 2'd1 && ptr_v_q) begin
                  ext_req_o <= 1'b1;
                end
                if (widx_q != 2'd3) widx_q <= widx_q + 2'd1;
              end
            end
          end
          ST_AACK: if (fall_i) begin
            if (rw_q) begin
              state_q <= ST_RBYTE; tx_q <= rd_byte; sda_oe_o <= ~rd_byte[7]; cnt_q <= '0;
            end else begin
              state_q <= ST_WBYTE; sda_oe_o <= 1'b0;
            end
          end
          ST_WACK: if (fall_i) begin
            state_q <= ST_WBYTE; sda_oe_o <= 1'b0;
          end
          ST_RBYTE: if (fall_i) begin
            if (cnt_q == 4'd7) begin
              sda_oe_o <= 1'b0; state_q <= ST_RACK;
              if (ridx_q != 2'd3) ridx_q <= ridx_q + 2'd1;
            end else begin
              cnt_q <= cnt_q + 4'd1; tx_q <= {tx_q[6:0], 1'b0}; sda_oe_o <= ~tx_q[6];
            end
          end
          ST_RACK: begin
            if (rise_i) mack_q <= ~sda_i;
            else if (fall_i) begin
              if (mack_q) begin
                state_q <= ST_RBYTE; tx_q <= rd_byte; sda_oe_o <= ~rd_byte[7]; cnt_q <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ext_sel_o = ptr_q;
  assign wdata_o   = sh_q;

  // R6: a read can only be acknowledged when no one-shot request is open
  assert_busy_nack_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_AACK && rw_q) |-> !busy_i);
endmodule

// File: rtl/pmon_cmd_regs.sv
module pmon_cmd_regs
  import pmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             ext_req_i,
  input  logic [1:0]       ext_sel_i,
  input  logic             shadow_ld_i,
  input  logic [RES_W-1:0] volt_res_i,
  input  logic             volt_done_i,
  input  logic [RES_W-1:0] curr_res_i,
  input  logic             curr_done_i,
  input  logic [7:0]       status_i,
  output logic             volt_cont_o,
  output logic             volt_once_o,
  output logic             curr_cont_o,
  output logic             curr_once_o,
  output logic             vrange_o,
  output logic             busy_o,
  output logic [23:0]      shadow_o,
  output logic             ext_wr_o,
  output logic [1:0]       ext_sel_o,
  output logic [7:0]       ext_data_o
);
  logic             en_v_q, en_i_q, st_sel_q;
  logic [RES_W-1:0] vres_q, ires_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      volt_cont_o <= 1'b0; volt_once_o <= 1'b0; curr_cont_o <= 1'b0;
      curr_once_o <= 1'b0; vrange_o <= 1'b0;
      en_v_q <= 1'b0; en_i_q <= 1'b0; st_sel_q <= 1'b0;
      vres_q <= '0; ires_q <= '0; shadow_o <= '0;
      ext_wr_o <= 1'b0; ext_sel_o <= '0; ext_data_o <= '0;
    end else begin
      ext_wr_o <= ext_req_i && (ext_sel_i != 2'd0);
      if (ext_req_i) begin
        ext_sel_o  <= ext_sel_i;
        ext_data_o <= wdata_i;
      end
      if (volt_done_i) begin vres_q <= volt_res_i; volt_once_o <= 1'b0; end
      if (curr_done_i) begin ires_q <= curr_res_i; curr_once_o <= 1'b0; end
      if (cmd_wr_i) begin
        volt_cont_o <= wdata_i[0];
        volt_once_o <= wdata_i[1];
        curr_cont_o <= wdata_i[2];
        curr_once_o <= wdata_i[3];
        vrange_o    <= wdata_i[4];
        st_sel_q    <= wdata_i[6];
        en_v_q      <= wdata_i[0] | wdata_i[1];
        en_i_q      <= wdata_i[2] | wdata_i[3];
        vres_q      <= '0;
        ires_q      <= '0;
      end
      if (shadow_ld_i)
        shadow_o <= pack_read(st_sel_q, en_v_q, en_i_q, vres_q, ires_q, status_i);
    end
  end

  assign busy_o = volt_once_o | curr_once_o;

  // R5: a done pulse closes the open voltage one-shot
  assert_once_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (volt_done_i && !cmd_wr_i) |=> !volt_once_o);
  // R3: a command write lands on the request outputs one cycle later
  assert_cmd_apply_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_wr_i |=> (volt_cont_o == $past(wdata_i[0]) && vrange_o == $past(wdata_i[4])));
  // R4: no strobe ever carries a zero selector
  assert_ext_sel_R4: assert property (@(posedge clk) disable iff (rst)
    ext_wr_o |-> ext_sel_o != 2'd0);
endmodule

// File: rtl/pmon_i2c_slave.sv
module pmon_i2c_slave
  import pmon_pkg::*;
#(
  parameter logic [4:0] ADDR_HI     = 5'b10110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       strap_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [RES_W-1:0] volt_res_i,
  input  logic             volt_done_i,
  input  logic [RES_W-1:0] curr_res_i,
  input  logic             curr_done_i,
  input  logic [7:0]       status_i,
  output logic             volt_cont_o,
  output logic             volt_once_o,
  output logic             curr_cont_o,
  output logic             curr_once_o,
  output logic             vrange_o,
  output logic             ext_wr_o,
  output logic [1:0]       ext_sel_o,
  output logic [7:0]       ext_data_o
);
  logic        sda_w, rise_w, fall_w, start_w, stop_w;
  logic        busy_w, cmd_wr_w, ext_req_w, shadow_ld_w;
  logic [1:0]  ptr_w;
  logic [7:0]  wdata_w;
  logic [23:0] shadow_w;

  pmon_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_w),
    .scl_rise_o(rise_w), .scl_fall_o(fall_w), .start_o(start_w), .stop_o(stop_w)
  );

  pmon_bus_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst(rst), .strap_i(strap_i), .sda_i(sda_w),
    .rise_i(rise_w), .fall_i(fall_w), .start_i(start_w), .stop_i(stop_w),
    .busy_i(busy_w), .shadow_i(shadow_w), .sda_oe_o(sda_oe_o),
    .cmd_wr_o(cmd_wr_w), .ext_req_o(ext_req_w), .ext_sel_o(ptr_w),
    .shadow_ld_o(shadow_ld_w), .wdata_o(wdata_w)
  );

  pmon_cmd_regs u_regs (
    .clk(clk), .rst(rst), .cmd_wr_i(cmd_wr_w), .wdata_i(wdata_w),
    .ext_req_i(ext_req_w), .ext_sel_i(ptr_w), .shadow_ld_i(shadow_ld_w),
    .volt_res_i(volt_res_i), .volt_done_i(volt_done_i),
    .curr_res_i(curr_res_i), .curr_done_i(curr_done_i), .status_i(status_i),
    .volt_cont_o(volt_cont_o), .volt_once_o(volt_once_o),
    .curr_cont_o(curr_cont_o), .curr_once_o(curr_once_o),
    .vrange_o(vrange_o), .busy_o(busy_w), .shadow_o(shadow_w),
    .ext_wr_o(ext_wr_o), .ext_sel_o(ext_sel_o), .ext_data_o(ext_data_o)
  );

  // R12: a STOP always leaves SDA released
  assert_stop_release_R12: assert property (@(posedge clk) disable iff (rst)
    stop_w |=> !sda_oe_o);
endmodule

// File: tb/test_pmon_i2c_slave.sv
module test_pmon_i2c_slave;
  localparam int Q = 10;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [11:0] v;
    logic [11:0] i;
    logic [7:0]  st;
    logic [1:0]  n;
    logic [23:0] exp;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'h05, 12'hABC, 12'h123, 8'h00, 2'd3, 24'hAB12C3},
    '{8'h01, 12'h5A7, 12'h999, 8'h00, 2'd2, 24'h5A7000},
    '{8'h04, 12'h111, 12'hF0E, 8'h00, 2'd2, 24'hF0E000},
    '{8'h0A, 12'h001, 12'hFFF, 8'h00, 2'd3, 24'h00FF1F},
    '{8'h41, 12'h777, 12'h888, 8'h3C, 2'd1, 24'h3C0000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] strap = 2'd0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;
  logic [11:0] vres = '0, ires = '0;
  logic vdone = 1'b0, idone = 1'b0;
  logic [7:0] status = '0;
  logic vcont, vonce, icont, ionce, vrange, ext_wr;
  logic [1:0] ext_sel;
  logic [7:0] ext_data;
  int nchk = 0, nfail = 0, ext_cnt = 0;
  logic [1:0] ext_sel_seen = '0;
  logic [7:0] ext_data_seen = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pmon_i2c_slave i_pmon_i2c_slave (
    .clk(clk), .rst(rst), .strap_i(strap), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .volt_res_i(vres), .volt_done_i(vdone),
    .curr_res_i(ires), .curr_done_i(idone), .status_i(status),
    .volt_cont_o(vcont), .volt_once_o(vonce), .curr_cont_o(icont),
    .curr_once_o(ionce), .vrange_o(vrange), .ext_wr_o(ext_wr),
    .ext_sel_o(ext_sel), .ext_data_o(ext_data)
  );

  always @(posedge clk) if (ext_wr) begin
    ext_cnt       <= ext_cnt + 1;
    ext_sel_seen  <= ext_sel;
    ext_data_seen <= ext_data;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int k = 7; k >= 0; k--) bit_out(d[k]);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); ack = ~sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      tick(Q); scl = 1'b1; tick(Q); d[k] = sda_bus; tick(Q); scl = 1'b0; tick(Q);
    end
    bit_out(~mack);
  endtask

  task automatic wr_txn(input logic [6:0] a, input int n, input logic [7:0] d0,
                        input logic [7:0] d1, output logic ok);
    logic ack;
    bus_start();
    wbyte({a, 1'b0}, ack);
    ok = ack;
    if (ack && n > 0) begin wbyte(d0, ack); ok = ok & ack; end
    if (ack && n > 1) begin wbyte(d1, ack); ok = ok & ack; end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [6:0] a, input int n, output logic ok,
                        output logic [23:0] data);
    logic [7:0] b;
    data = '0;
    bus_start();
    wbyte({a, 1'b1}, ok);
    if (ok) for (int k = 0; k < n; k++) begin
      rbyte(k < n - 1, b);
      data[23-8*k -: 8] = b;
    end
    bus_stop();
  endtask

  task automatic pulse_done(input logic [11:0] v, input logic [11:0] i);
    vres = v; ires = i; vdone = 1'b1; idone = 1'b1; tick(1); vdone = 1'b0; idone = 1'b0; tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail);
      $finish;
    end
  end

  initial begin
    logic ok;
    logic [23:0] d;
    logic [7:0] b;
    tick(5); rst = 1'b0; tick(5);

    // Reset state
    chk("R3 reset outputs", {vcont, vonce, icont, ionce, vrange, ext_wr}, 0);
    chk("R12 reset sda released", sda_oe, 0);

    // Readback vector table
    foreach (VEC[k]) begin
      wr_txn(7'h58, 1, VEC[k].cmd, 8'h00, ok);
      chk("R3 command write ack", ok, 1);
      status = VEC[k].st;
      pulse_done(VEC[k].v, VEC[k].i);
      rd_txn(7'h58, VEC[k].n, ok, d);
      chk("R1 read ack", ok, 1);
      if (VEC[k].n == 2'd3)      chk("R8 three-byte packing", d, VEC[k].exp);
      else if (VEC[k].n == 2'd2) chk("R9 two-byte packing", d, VEC[k].exp);
      else                       chk("R10 status byte", d, VEC[k].exp);
    end

    // R1: address match with two straps
    wr_txn(7'h5A, 0, 8'h00, 8'h00, ok);
    chk("R1 foreign address nack", ok, 0);
    strap = 2'd2; tick(2);
    wr_txn(7'h5A, 0, 8'h00, 8'h00, ok);
    chk("R1 strap 10 address ack", ok, 1);
    wr_txn(7'h58, 0, 8'h00, 8'h00, ok);
    chk("R1 old address nack", ok, 0);
    strap = 2'd0; tick(2);

    // R3 fields
    wr_txn(7'h58, 1, 8'h35, 8'h00, ok);
    chk("R3 fields 0x35", {vcont, vonce, icont, ionce, vrange}, 5'b10101);

    // R2 quick command
    wr_txn(7'h58, 0, 8'h00, 8'h00, ok);
    chk("R2 quick command ack", ok, 1);
    chk("R2 quick command no effect", {vcont, vonce, icont, ionce, vrange, ext_cnt[0]}, 6'b101010);

    // R7 continuous before first result
    wr_txn(7'h58, 1, 8'h05, 8'h00, ok);
    rd_txn(7'h58, 3, ok, d);
    chk("R7 continuous early read ack", ok, 1);
    chk("R7 continuous early read zeros", d, 0);

    // R5 / R6 one-shot
    wr_txn(7'h58, 1, 8'h02, 8'h00, ok);
    chk("R5 volt one-shot raised", vonce, 1);
    rd_txn(7'h58, 2, ok, d);
    chk("R6 read nack while pending", ok, 0);
    wr_txn(7'h58, 0, 8'h00, 8'h00, ok);
    chk("R6 write ack while pending", ok, 1);
    pulse_done(12'h9C4, 12'h000);
    chk("R5 volt one-shot cleared", vonce, 0);
    rd_txn(7'h58, 2, ok, d);
    chk("R6 read ack after done", ok, 1);
    chk("R9 one-shot data", d, 24'h9C4000);
    wr_txn(7'h58, 1, 8'h08, 8'h00, ok);
    chk("R5 curr one-shot raised", ionce, 1);
    pulse_done(12'h000, 12'h321);
    chk("R5 curr one-shot cleared", ionce, 0);

    // R4 extended writes
    wr_txn(7'h58, 2, 8'h82, 8'h5D, ok);
    tick(2);
    chk("R4 ext strobe count", ext_cnt, 1);
    chk("R4 ext sel/data", {ext_sel_seen, ext_data_seen}, {2'd2, 8'h5D});
    wr_txn(7'h58, 2, 8'h80, 8'h11, ok);
    tick(2);
    chk("R4 selector zero no strobe", ext_cnt, 1);

    // R11 release after master nack
    wr_txn(7'h58, 1, 8'h01, 8'h00, ok);
    bus_start();
    wbyte({7'h58, 1'b1}, ok);
    rbyte(1'b1, b);
    rbyte(1'b0, b);
    tick(Q);
    chk("R11 sda released after nack", sda_oe, 0);
    scl = 1'b1; tick(Q);
    chk("R11 sda still released", sda_oe, 0);
    scl = 1'b0; tick(Q);
    bus_stop();

    // R12 byte cut by STOP
    bus_start();
    wbyte({7'h58, 1'b0}, ok);
    bit_out(1'b0); bit_out(1'b0); bit_out(1'b0); bit_out(1'b1);
    bus_stop();
    tick(3);
    chk("R12 cut byte no effect", {vcont, icont, vrange}, 3'b100);
    chk("R12 sda released after stop", sda_oe, 0);
    wr_txn(7'h58, 1, 8'h15, 8'h00, ok);
    chk("R12 next transfer works", {ok, vcont, vrange}, 3'b111);

    // R13 shadow
    wr_txn(7'h58, 1, 8'h05, 8'h00, ok);
    pulse_done(12'h111, 12'h222);
    bus_start();
    wbyte({7'h58, 1'b1}, ok);
    rbyte(1'b1, d[23:16]);
    pulse_done(12'hEEE, 12'hDDD);
    rbyte(1'b1, d[15:8]);
    rbyte(1'b0, d[7:0]);
    bus_stop();
    chk("R13 shadow bytes frozen", d, 24'h112212);
    rd_txn(7'h58, 3, ok, d);
    chk("R13 next read sees new data", d, 24'hEEDDED);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule